// File: doc/BRIEF.md
# CAN Transmit/Receive Error Counters

This block holds the two fault-confinement error counters of a CAN node: one for transmit errors and one for receive errors. The protocol engine, which is outside the block, sends single-cycle event pulses when a frame is sent or received cleanly and when a transmit or receive error is detected. The block moves the counters by the standard fault-confinement steps. It raises an error-passive flag and a bus-off flag from the counter values, and it clears both counters when the node goes bus-off or when the controller's reset-request control bit is high.

A host reads both counters through one 16-bit register: the transmit count in the upper byte and the receive count in the lower byte. That register cannot be written in normal operation. There is one exception, for test only. When the 3-bit test selector holds the error-counter-write code and the controller is halted, a host write loads the upper byte of the write data into both counters at the same time. The event pulses and the host strobes are plain single-cycle control signals with no back-pressure. There is no valid/ready handshake, because neither the counters nor the host side can stall.

Top module: `can_err_counters`

## Requirements
- R1: After rst_n is released, both counters are 0, host_rdata is 0, and err_passive and bus_off are low.
- R2: A cycle with ev_tx_err raises the transmit counter by 8. A cycle with only ev_tx_ok lowers it by 1, and it stays at 0 when it is already 0.
- R3: A cycle with ev_rx_err raises the receive counter by 1, up to 255, where it holds. A cycle with only ev_rx_ok lowers it by 1 when it is between 1 and 127, sets it to 120 when it is above 127, and leaves it at 0 when it is 0.
- R4: err_passive is high exactly when bus_off is low and either counter is above 127.
- R5: When the internal transmit count is above 255 and the node is not bus-off, the next edge sets bus_off and clears both counters. While bus_off is high, the error and success events have no effect on the counters.
- R6: A cycle with reset_req high clears both counters and bus_off on the next edge. This takes priority over every other update.
- R7: When host_wr is high, test_sel equals 3'b100 and halt_mode is high, the next edge loads host_wdata[15:8] into both counters. This takes priority over the events in the same cycle, but not over reset_req or bus-off entry.
- R8: A host_wr with test_sel other than 3'b100, or with halt_mode low, has no effect on either counter.
- R9: On each edge where host_rd is high, host_rdata is loaded with the transmit counter in bits 15:8 and the receive counter in bits 7:0. The values are those from before any update on that same edge, and the transmit field shows 255 when the internal count is above 255. host_rdata holds its value when host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Controller reset-request bit; clears counters and bus-off |
| halt_mode | input | 1 | Controller is halted |
| test_sel | input | 3 | Test mode selector; 3'b100 enables counter writes |
| ev_tx_err | input | 1 | Transmit error event pulse |
| ev_tx_ok | input | 1 | Successful transmission pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_rx_ok | input | 1 | Successful reception pulse |
| host_wr | input | 1 | Host write strobe for the counter register |
| host_wdata | input | 16 | Host write data; bits 15:8 are used |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered read data {tx, rx} |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The assertions assume that the protocol engine never raises a transmit error and a transmit success in the same cycle, and never a receive error and a receive success together. One checker property states each of these assumptions, so a breach is reported rather than silently resolved. The stimulus draws each direction's event from a single random choice among error, success and none, so the pair can never coincide. The reset request, the test selector, the halt flag and the host strobes are random with no constraint, so every combination of write gating and priority is reached.

// File: rtl/can_ec_pkg.sv
package can_ec_pkg;
  localparam int          EC_CNT_W     = 8;
  localparam int          EC_TX_STEP   = 8;
  localparam int          EC_PASS_LIM  = 127;
  localparam int          EC_RX_BOUNCE = 120;
  localparam int          EC_TSEL_W    = 3;
  localparam logic [2:0]  EC_TSEL_WR   = 3'b100;
endpackage

// File: rtl/can_ec_txcnt.sv
module can_ec_txcnt #(
  parameter int CNT_W = 8,
  parameter int STEP  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic [CNT_W-1:0] load_val,
  input  logic           freeze,
  input  logic           inc,
  input  logic           dec,
  output logic [CNT_W:0] cnt
);
  localparam int W = CNT_W + 1;
  localparam logic [W-1:0] STEP_V = W'(STEP);
  localparam logic [W-1:0] ONE_V  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (load)                 cnt_d = {1'b0, load_val};
    else if (freeze)               cnt_d = cnt_q;
    else if (inc)                  cnt_d = cnt_q + STEP_V;
    else if (dec && cnt_q != '0)   cnt_d = cnt_q - ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign cnt = cnt_q;
endmodule

// File: rtl/can_ec_rxcnt.sv
module can_ec_rxcnt #(
  parameter int CNT_W  = 8,
  parameter int LIM    = 127,
  parameter int BOUNCE = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             freeze,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LIM_V    = CNT_W'(LIM);
  localparam logic [CNT_W-1:0] BOUNCE_V = CNT_W'(BOUNCE);
  localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_V    = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (load)   cnt_d = load_val;
    else if (freeze) cnt_d = cnt_q;
    else if (inc) begin
      if (cnt_q != MAX_V) cnt_d = cnt_q + ONE_V;
    end else if (dec) begin
      if (cnt_q > LIM_V)       cnt_d = BOUNCE_V;
      else if (cnt_q != '0)    cnt_d = cnt_q - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign cnt = cnt_q;
endmodule

// File: rtl/can_ec_hostif.sv
module can_ec_hostif #(
  parameter int            CNT_W  = 8,
  parameter int            TSEL_W = 3,
  parameter logic [TSEL_W-1:0] TSEL_WR = 3'b100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TSEL_W-1:0]  test_sel,
  input  logic               halt_mode,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [CNT_W:0]     tx_cnt,
  input  logic [CNT_W-1:0]   rx_cnt,
  output logic               wr_go,
  output logic [2*CNT_W-1:0] rdata
);
  logic [CNT_W-1:0]   tx_view;
  logic [2*CNT_W-1:0] rdata_q;

  assign wr_go   = host_wr && halt_mode && (test_sel == TSEL_WR);
  assign tx_view = tx_cnt[CNT_W] ? '1 : tx_cnt[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= {tx_view, rx_cnt};

  assign rdata = rdata_q;
endmodule

// File: rtl/can_err_counters.sv
module can_err_counters
  import can_ec_pkg::*;
#(
  parameter int CNT_W    = EC_CNT_W,
  parameter int TX_STEP  = EC_TX_STEP,
  parameter int PASS_LIM = EC_PASS_LIM,
  parameter int RX_BOUNCE = EC_RX_BOUNCE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reset_req,
  input  logic                 halt_mode,
  input  logic [EC_TSEL_W-1:0] test_sel,
  input  logic                 ev_tx_err,
  input  logic                 ev_tx_ok,
  input  logic                 ev_rx_err,
  input  logic                 ev_rx_ok,
  input  logic                 host_wr,
  input  logic [2*CNT_W-1:0]   host_wdata,
  input  logic                 host_rd,
  output logic [2*CNT_W-1:0]   host_rdata,
  output logic                 err_passive,
  output logic                 bus_off
);
  localparam logic [CNT_W:0] PASS_V = (CNT_W+1)'(PASS_LIM);

  logic [CNT_W:0]   tx_cnt;
  logic [CNT_W-1:0] rx_cnt;
  logic             boff_q, boff_entry, clr, wr_go;

  assign boff_entry = tx_cnt[CNT_W] && !boff_q;
  assign clr        = reset_req || boff_entry;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          boff_q <= 1'b0;
    else if (reset_req)  boff_q <= 1'b0;
    else if (boff_entry) boff_q <= 1'b1;

  can_ec_hostif #(.CNT_W(CNT_W), .TSEL_W(EC_TSEL_W), .TSEL_WR(EC_TSEL_WR)) u_host (
    .clk(clk), .rst_n(rst_n), .test_sel(test_sel), .halt_mode(halt_mode),
    .host_wr(host_wr), .host_rd(host_rd), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .wr_go(wr_go), .rdata(host_rdata)
  );

  can_ec_txcnt #(.CNT_W(CNT_W), .STEP(TX_STEP)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(wr_go),
    .load_val(host_wdata[2*CNT_W-1:CNT_W]), .freeze(boff_q),
    .inc(ev_tx_err), .dec(ev_tx_ok), .cnt(tx_cnt)
  );

  can_ec_rxcnt #(.CNT_W(CNT_W), .LIM(PASS_LIM), .BOUNCE(RX_BOUNCE)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(wr_go),
    .load_val(host_wdata[2*CNT_W-1:CNT_W]), .freeze(boff_q),
    .inc(ev_rx_err), .dec(ev_rx_ok), .cnt(rx_cnt)
  );

  assign bus_off     = boff_q;
  assign err_passive = !boff_q && ((tx_cnt > PASS_V) || ({1'b0, rx_cnt} > PASS_V));
endmodule

// File: rtl/can_err_counters_chk.sv
module can_err_counters_chk
  import can_ec_pkg::*;
#(
  parameter int CNT_W     = EC_CNT_W,
  parameter int TX_STEP   = EC_TX_STEP,
  parameter int PASS_LIM  = EC_PASS_LIM,
  parameter int RX_BOUNCE = EC_RX_BOUNCE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reset_req,
  input logic                 halt_mode,
  input logic [EC_TSEL_W-1:0] test_sel,
  input logic                 ev_tx_err,
  input logic                 ev_tx_ok,
  input logic                 ev_rx_err,
  input logic                 ev_rx_ok,
  input logic                 host_wr,
  input logic                 host_rd,
  input logic [2*CNT_W-1:0]   host_rdata,
  input logic                 bus_off,
  input logic [CNT_W:0]       tx_cnt,
  input logic [CNT_W-1:0]     rx_cnt
);
  logic wr_ok, quiet;
  assign wr_ok = host_wr && halt_mode && (test_sel == EC_TSEL_WR);
  assign quiet = !reset_req && !bus_off && !tx_cnt[CNT_W];

  AST_TX_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_tx_err && ev_tx_ok)); // R2
  AST_RX_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx_err && ev_rx_ok)); // R3
  AST_TX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_err && quiet && !wr_ok) |=> tx_cnt == $past(tx_cnt) + (CNT_W+1)'(TX_STEP)); // R2
  AST_RX_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ok && !ev_rx_err && quiet && !wr_ok && rx_cnt > CNT_W'(PASS_LIM))
      |=> rx_cnt == CNT_W'(RX_BOUNCE)); // R3
  AST_BOFF_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt[CNT_W] && !bus_off && !reset_req) |=> bus_off && tx_cnt == '0 && rx_cnt == '0); // R5
  AST_BOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !reset_req && !wr_ok) |=> $stable(tx_cnt) && $stable(rx_cnt)); // R5
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> tx_cnt == '0 && rx_cnt == '0 && !bus_off); // R6
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !wr_ok && quiet && !ev_tx_err && !ev_tx_ok && !ev_rx_err && !ev_rx_ok)
      |=> $stable(tx_cnt) && $stable(rx_cnt)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata)); // R9
endmodule

bind can_err_counters can_err_counters_chk #(
  .CNT_W(CNT_W), .TX_STEP(TX_STEP), .PASS_LIM(PASS_LIM), .RX_BOUNCE(RX_BOUNCE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .halt_mode(halt_mode),
  .test_sel(test_sel), .ev_tx_err(ev_tx_err), .ev_tx_ok(ev_tx_ok),
  .ev_rx_err(ev_rx_err), .ev_rx_ok(ev_rx_ok), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .bus_off(bus_off),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/can_err_counters_bench.sv
module can_err_counters_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0, halt_mode = 1'b0;
  logic [2:0]  test_sel = 3'b000;
  logic        ev_tx_err = 1'b0, ev_tx_ok = 1'b0, ev_rx_err = 1'b0, ev_rx_ok = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = 16'h0000;
  logic [15:0] host_rdata;
  logic        err_passive, bus_off;

  int checks_n = 0, errors_n = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_tx = 0, m_rx = 0, m_rd = 0;
  bit m_boff = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  can_err_counters u_can_err_counters (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .halt_mode(halt_mode),
    .test_sel(test_sel), .ev_tx_err(ev_tx_err), .ev_tx_ok(ev_tx_ok),
    .ev_rx_err(ev_rx_err), .ev_rx_ok(ev_rx_ok), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .err_passive(err_passive), .bus_off(bus_off)
  );

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_rd = 0; m_boff = 1'b0;
    end else begin
      if (host_rd) m_rd = ((m_tx > 255 ? 255 : m_tx) * 256) + m_rx;
      if (reset_req) begin
        m_tx = 0; m_rx = 0; m_boff = 1'b0;
      end else if (!m_boff && m_tx > 255) begin
        m_tx = 0; m_rx = 0; m_boff = 1'b1;
      end else if (host_wr && halt_mode && test_sel == 3'b100) begin
        m_tx = int'(host_wdata[15:8]); m_rx = m_tx;
      end else if (!m_boff) begin
        if (ev_tx_err) m_tx = m_tx + 8;
        else if (ev_tx_ok && m_tx > 0) m_tx = m_tx - 1;
        if (ev_rx_err) begin
          if (m_rx < 255) m_rx = m_rx + 1;
        end else if (ev_rx_ok) begin
          if (m_rx > 127) m_rx = 120;
          else if (m_rx > 0) m_rx = m_rx - 1;
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks_n++;
    if (act != exp) begin
      errors_n++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      check("host_rdata", int'(host_rdata), m_rd);
      check("bus_off", int'(bus_off), int'(m_boff));
      check("err_passive (R4)", int'(err_passive),
            int'(!m_boff && (m_tx > 127 || m_rx > 127)));
    end
  endtask

  task automatic idle();
    ev_tx_err = 0; ev_tx_ok = 0; ev_rx_err = 0; ev_rx_ok = 0;
    host_wr = 0; reset_req = 0; host_rd = 1;
  endtask

  task automatic pulse(bit te, bit tk, bit re, bit rk, int n);
    for (int i = 0; i < n; i++) begin
      idle(); ev_tx_err = te; ev_tx_ok = tk; ev_rx_err = re; ev_rx_ok = rk;
      step();
    end
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks_n, errors_n);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors_n++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    step(); step();
    rst_n = 1'b1;
    tag = "R1"; step(); step();
    check("R1 rdata after reset", int'(host_rdata), 0);
    check("R1 bus_off after reset", int'(bus_off), 0);
    tag = "R2"; pulse(1, 0, 0, 0, 20); step();
    check("R2 tx after 20 errors", int'(host_rdata[15:8]), 160);
    tag = "R4"; check("R4 passive at tx 160", int'(err_passive), 1);
    tag = "R2"; pulse(0, 1, 0, 0, 170); step();
    check("R2 tx floors at 0", int'(host_rdata[15:8]), 0);
    tag = "R3"; pulse(0, 0, 1, 0, 130); step();
    check("R3 rx rise", int'(host_rdata[7:0]), 130);
    pulse(0, 0, 0, 1, 1); step();
    check("R3 rx bounce", int'(host_rdata[7:0]), 120);
    pulse(0, 0, 1, 0, 200); step();
    check("R3 rx saturates", int'(host_rdata[7:0]), 255);
    tag = "R6"; reset_req = 1; step(); idle(); step();
    check("R6 cleared", int'(host_rdata), 0);
    tag = "R5"; pulse(1, 0, 1, 0, 33); step(); step();
    check("R5 bus_off set", int'(bus_off), 1);
    pulse(1, 0, 1, 0, 10); step();
    check("R5 frozen in bus-off", int'(host_rdata), 0);
    tag = "R6"; reset_req = 1; step(); idle(); step();
    check("R6 leaves bus-off", int'(bus_off), 0);
    tag = "R7"; host_wr = 1; halt_mode = 1; test_sel = 3'b100; host_wdata = 16'hA355;
    ev_tx_err = 1; step(); idle(); step();
    check("R7 both loaded", int'(host_rdata), 16'hA3A3);
    tag = "R8"; host_wr = 1; halt_mode = 0; host_wdata = 16'h1111; step();
    host_wr = 1; halt_mode = 1; test_sel = 3'b101; step(); idle(); step();
    check("R8 write ignored", int'(host_rdata), 16'hA3A3);
    tag = "R9"; host_rd = 0; ev_rx_err = 1; step(); step(); idle(); host_rd = 0; step();
    check("R9 rdata held", int'(host_rdata), 16'hA3A3);
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      int t, r;
      idle();
      t = $urandom % 4; r = $urandom % 4;
      ev_tx_err = (t == 0); ev_tx_ok = (t == 1);
      ev_rx_err = (r == 0); ev_rx_ok = (r == 1);
      reset_req = ($urandom % 64) == 0;
      host_rd   = ($urandom % 4) != 0;
      host_wr   = ($urandom % 8) == 0;
      halt_mode = $urandom % 2;
      test_sel  = (($urandom % 2) == 0) ? 3'b100 : 3'($urandom);
      host_wdata = 16'($urandom);
      step();
    end
    idle(); step();
    finish_run();
  end
endmodule